// File: doc/BRIEF.md
# Dual-Target Time Serial Port

This block shifts a control word of programmable length out of one data pin toward one of two kinds of peripheral. Both kinds share the 13 MHz serial clock, which is the block's own clock, and the single data-out line. A scheduler pulses a start input together with a target select, the word and a bit count. The block then frames and shifts the word and reports busy until the framing line is back at rest.

The first kind of target is framed by an active-high strobe and samples data on every rising edge of the 13 MHz clock. The second kind divides the 13 MHz clock by two internally and samples on its own rising edge, whose phase the block does not know. For that target every bit is therefore held for two full 13 MHz periods, and the frame is marked by an active-low enable. All output pins change on the falling clock edge, so that each value is stable half a period before the rising edge at which a target samples it.

Top module: `dual_tsp`

## Requirements
- R1: While reset (`rst_n` low, sampled on both clock edges) is applied, and at any time the block is not busy, `data_o` is 0, `strobe_o` is 0, `en_n_o` is 1 and `busy_o` is 0.
- R2: The bits sent are `word_i[n-1:0]`, where n is the effective bit count, and bit n-1 is sent first.
- R3: Output pins change only on the falling clock edge. After the rising edge that accepts a start, `data_o` keeps its old value until the next falling edge.
- R4: `sel_i` = 0 picks the strobe target. Bit k (0-based) is on `data_o` at the (k+1)-th rising edge after the accepting edge, one bit per clock.
- R5: For the strobe target, `strobe_o` is 1 at exactly one rising edge: the edge after the last bit. `en_n_o` stays 1 for the whole transfer.
- R6: `sel_i` = 1 picks the enable target. Bit k is on `data_o` at rising edges 2k+1 and 2k+2 after the accepting edge. `strobe_o` stays 0.
- R7: For the enable target, `en_n_o` is 0 from the first bit through two further clocks after the last bit, and is 1 at the next edge after that.
- R8: `busy_o` is 1 from the accepting edge until the framing line has returned to idle. A start while busy is ignored, including its select, word and count.
- R9: The effective bit count equals `nbits_i` for values 1 to 32. A value of 0 or 33 to 63 is treated as 32.
- R10: `data_o` is 0 whenever no data bit is being sent, including while the strobe pulse or the enable tail is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13 MHz serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| sel_i | input | 1 | Target kind: 0 strobe-framed, 1 enable-framed |
| word_i | input | 32 | Word to send, right-aligned |
| nbits_i | input | 6 | Number of bits to send |
| busy_o | output | 1 | Transfer or framing in progress |
| data_o | output | 1 | Shared serial data line |
| strobe_o | output | 1 | Active-high frame strobe, first target |
| en_n_o | output | 1 | Active-low frame enable, second target |

## Verification
A table of transfers covers both targets with asymmetric words such as 0xA5 and 0x80000001. These words tell most-significant-first order apart from the reverse, and show whether the alignment of short words is correct. Bit counts of 1 and 32 test the ends of the range, while 0 and 40 show whether out-of-range counts clamp to 32. Directed cases sample just after a rising edge to separate falling-edge launch from rising-edge launch. A start with a different select and word is pulsed in the middle of a transfer to show that a busy block ignores it, and a reset is applied mid-frame.

// File: rtl/tsp_pkg.sv
// Shared types for the dual-target time serial port.
// Assumes: one clock domain, the 13 MHz serial clock.
package tsp_pkg;

    // Transfer phase of the controller.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SHIFT  = 2'd1,
        PH_STROBE = 2'd2,
        PH_TAIL   = 2'd3
    } tsp_phase_e;

    // Kind of target addressed; the value equals the select input.
    typedef enum logic {
        TGT_STROBE = 1'b0,
        TGT_ENABLE = 1'b1
    } tsp_target_e;

endpackage

// File: rtl/tsp_ctrl.sv
// Transfer controller. It accepts a start while the line is idle and steps
// through the shift, strobe or tail phases. It counts the bits, and for each
// bit it counts the clocks that bit is held.
// Assumes: line_busy_i reflects the output pins; start_i is synchronous.
module tsp_ctrl
    import tsp_pkg::*;
#(
    parameter int MAX_BITS  = 32,
    parameter int SLOW_HOLD = 2,
    localparam int NB_W     = $clog2(MAX_BITS + 1),
    localparam int HOLD_W   = $clog2(SLOW_HOLD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sel_i,
    input  logic [NB_W-1:0]   nbits_i,
    input  logic              line_busy_i,
    output tsp_phase_e        phase_o,
    output tsp_target_e       tgt_o,
    output logic              load_o,
    output logic              shift_o,
    output logic [NB_W-1:0]   nbits_eff_o
);

    tsp_phase_e        phase_q;
    tsp_target_e       tgt_q;
    logic [NB_W-1:0]   left_q;
    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] hold_last;
    logic              hold_done;
    logic              accept;

    // Clamp an out-of-range or zero count to the maximum length.
    always_comb begin
        if (nbits_i == '0 || nbits_i > NB_W'(MAX_BITS))
            nbits_eff_o = NB_W'(MAX_BITS);
        else
            nbits_eff_o = nbits_i;
    end

    // Number of clocks per bit depends on the latched target.
    always_comb begin
        hold_last = (tgt_q == TGT_ENABLE) ? HOLD_W'(SLOW_HOLD - 1) : '0;
        hold_done = (hold_q == hold_last);
    end

    // Start is taken only while both the controller and the pins are at rest.
    always_comb begin
        accept  = start_i && !line_busy_i;
        load_o  = accept;
        shift_o = (phase_q == PH_SHIFT) && hold_done && (left_q != NB_W'(1));
    end

    // Phase, target, bit counter and hold counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            tgt_q   <= TGT_STROBE;
            left_q  <= '0;
            hold_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q <= PH_SHIFT;
                        tgt_q   <= tsp_target_e'(sel_i);
                        left_q  <= nbits_eff_o;
                        hold_q  <= '0;
                    end
                end
                PH_SHIFT: begin
                    if (hold_done) begin
                        hold_q <= '0;
                        if (left_q == NB_W'(1))
                            phase_q <= (tgt_q == TGT_ENABLE) ? PH_TAIL : PH_STROBE;
                        else
                            left_q <= left_q - NB_W'(1);
                    end else begin
                        hold_q <= hold_q + HOLD_W'(1);
                    end
                end
                PH_STROBE: begin
                    phase_q <= PH_IDLE;
                end
                PH_TAIL: begin
                    if (hold_done) begin
                        hold_q  <= '0;
                        phase_q <= PH_IDLE;
                    end else begin
                        hold_q <= hold_q + HOLD_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign tgt_o   = tgt_q;

endmodule

// File: rtl/tsp_shifter.sv
// Shift register. On load it left-aligns the low n bits of the word so that
// bit n-1 sits at the top, and on each shift it moves one place toward the
// top. Its output is the current top bit.
// Assumes: load and shift are never high together.
module tsp_shifter #(
    parameter int MAX_BITS = 32,
    localparam int NB_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                shift_i,
    input  logic [MAX_BITS-1:0] word_i,
    input  logic [NB_W-1:0]     nbits_i,
    output logic                bit_o
);

    logic [MAX_BITS-1:0] sr_q;
    logic [NB_W-1:0]     pad;

    // Distance to move the word so its first bit lands at the top.
    always_comb pad = NB_W'(MAX_BITS) - nbits_i;

    // Load aligned word or advance by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (load_i)
            sr_q <= word_i << pad;
        else if (shift_i)
            sr_q <= {sr_q[MAX_BITS-2:0], 1'b0};
    end

    assign bit_o = sr_q[MAX_BITS-1];

endmodule

// File: rtl/tsp_launch.sv
// Output stage clocked on the falling edge. It converts the controller phase
// into pin levels, so that every pin is stable half a period before the
// rising edge at which a target samples it.
// Assumes: rst_n is held for at least one falling edge.
module tsp_launch
    import tsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  tsp_phase_e  phase_i,
    input  tsp_target_e tgt_i,
    input  logic        bit_i,
    output logic        data_o,
    output logic        strobe_o,
    output logic        en_n_o
);

    logic data_d;
    logic strobe_d;
    logic en_n_d;

    // Pin levels implied by the current phase.
    always_comb begin
        data_d   = (phase_i == PH_SHIFT) && bit_i;
        strobe_d = (phase_i == PH_STROBE);
        en_n_d   = !((tgt_i == TGT_ENABLE) &&
                     (phase_i == PH_SHIFT || phase_i == PH_TAIL));
    end

    // Register pins on the falling edge; idle levels under reset.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            data_o   <= 1'b0;
            strobe_o <= 1'b0;
            en_n_o   <= 1'b1;
        end else begin
            data_o   <= data_d;
            strobe_o <= strobe_d;
            en_n_o   <= en_n_d;
        end
    end

endmodule

// File: rtl/dual_tsp.sv
// Top of the dual-target time serial port. It connects the controller, the
// shifter and the falling-edge launch stage. Busy covers the controller's
// activity and any framing pin that has not yet returned to rest.
// Assumes: clk is the shared 13 MHz serial clock; inputs are synchronous.
module dual_tsp
    import tsp_pkg::*;
#(
    parameter int MAX_BITS  = 32,
    parameter int SLOW_HOLD = 2,
    localparam int NB_W     = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                sel_i,
    input  logic [MAX_BITS-1:0] word_i,
    input  logic [NB_W-1:0]     nbits_i,
    output logic                busy_o,
    output logic                data_o,
    output logic                strobe_o,
    output logic                en_n_o
);

    tsp_phase_e      phase;
    tsp_target_e     tgt;
    logic            load;
    logic            shift;
    logic            top_bit;
    logic [NB_W-1:0] nbits_eff;

    // Busy until both the controller and the framing pins are at rest.
    always_comb busy_o = (phase != PH_IDLE) || strobe_o || !en_n_o;

    tsp_ctrl #(
        .MAX_BITS  (MAX_BITS),
        .SLOW_HOLD (SLOW_HOLD)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .sel_i       (sel_i),
        .nbits_i     (nbits_i),
        .line_busy_i (busy_o),
        .phase_o     (phase),
        .tgt_o       (tgt),
        .load_o      (load),
        .shift_o     (shift),
        .nbits_eff_o (nbits_eff)
    );

    tsp_shifter #(
        .MAX_BITS (MAX_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .word_i  (word_i),
        .nbits_i (nbits_eff),
        .bit_o   (top_bit)
    );

    tsp_launch u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_i  (phase),
        .tgt_i    (tgt),
        .bit_i    (top_bit),
        .data_o   (data_o),
        .strobe_o (strobe_o),
        .en_n_o   (en_n_o)
    );

endmodule

// File: rtl/tsp_checker.sv
// Protocol checker for dual_tsp, attached to it by bind. It samples the pins
// on the rising edge, which is the point at which a target reads them.
module tsp_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic data_o,
    input logic strobe_o,
    input logic en_n_o
);

    AST_IDLE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !data_o); // R1

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R8

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o); // R5

    AST_FRAMES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_o && !en_n_o)); // R6

    AST_STROBE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> !data_o); // R10

    AST_ENABLE_RELEASE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_n_o) |-> !data_o); // R7

endmodule

bind dual_tsp tsp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .data_o   (data_o),
    .strobe_o (strobe_o),
    .en_n_o   (en_n_o)
);

// File: tb/tb_dual_tsp.sv
// Bench for dual_tsp. Inputs are driven 1 ns after a rising edge. Outputs are
// sampled 2 ns after a falling edge, which is just before the rising edge at
// which a target reads them.
module tb_dual_tsp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sel_i = 1'b0;
    logic [31:0] word_i = '0;
    logic [5:0]  nbits_i = '0;
    logic        busy_o, data_o, strobe_o, en_n_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dual_tsp dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .word_i(word_i), .nbits_i(nbits_i), .busy_o(busy_o),
        .data_o(data_o), .strobe_o(strobe_o), .en_n_o(en_n_o)
    );

    // Entry: {sel, nbits, word}
    localparam int NVEC = 8;
    localparam logic [38:0] VEC [NVEC] = '{
        {1'b0, 6'd8,  32'h0000_00A5},
        {1'b0, 6'd1,  32'h0000_0001},
        {1'b0, 6'd32, 32'h8000_0001},
        {1'b1, 6'd4,  32'h0000_000B},
        {1'b1, 6'd16, 32'h0000_1234},
        {1'b1, 6'd0,  32'hF0F0_3C5A},
        {1'b0, 6'd40, 32'hDEAD_BEEF},
        {1'b1, 6'd1,  32'h0000_0001}
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic sample();
        @(negedge clk);
        #2;
    endtask

    function automatic int eff_n(input logic [5:0] n);
        return (n == 0 || n > 32) ? 32 : int'(n);
    endfunction

    // One transfer. If poke > 0, a start with other inputs is pulsed before edge 'poke'.
    task automatic xfer(input logic s, input logic [5:0] n, input logic [31:0] w, input int poke);
        int ne = eff_n(n);
        int span = s ? 2 * ne : ne;
        @(posedge clk); #1;
        start_i = 1'b1; sel_i = s; nbits_i = n; word_i = w;
        @(posedge clk); #1;
        start_i = 1'b0;
        for (int c = 1; c <= span; c++) begin
            sample();
            if (c == poke + 1 && poke > 0) start_i = 1'b0;
            chk(s ? "R6" : "R4", "data bit", data_o, w[ne - 1 - (s ? (c - 1) / 2 : c - 1)]);
            chk("R8", "busy during bits", busy_o, 1'b1);
            if (s) begin
                chk("R7", "enable low during bits", en_n_o, 1'b0);
                chk("R6", "strobe stays low", strobe_o, 1'b0);
            end else begin
                chk("R5", "enable stays high", en_n_o, 1'b1);
                chk("R5", "no early strobe", strobe_o, 1'b0);
            end
            if (c == poke) begin
                start_i = 1'b1; sel_i = ~s; word_i = ~w; nbits_i = 6'd3;
            end
        end
        start_i = 1'b0;
        if (s) begin
            for (int t = 0; t < 2; t++) begin
                sample();
                chk("R7", "enable tail low", en_n_o, 1'b0);
                chk("R10", "data low in tail", data_o, 1'b0);
                chk("R8", "busy in tail", busy_o, 1'b1);
            end
        end else begin
            sample();
            chk("R5", "strobe after last bit", strobe_o, 1'b1);
            chk("R10", "data low at strobe", data_o, 1'b0);
            chk("R8", "busy at strobe", busy_o, 1'b1);
        end
        sample();
        chk("R1", "idle data", data_o, 1'b0);
        chk(s ? "R7" : "R5", "strobe idle", strobe_o, 1'b0);
        chk(s ? "R7" : "R1", "enable idle", en_n_o, 1'b1);
        chk("R8", "busy cleared", busy_o, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset levels
        repeat (3) @(posedge clk);
        sample();
        chk("R1", "reset data", data_o, 1'b0);
        chk("R1", "reset strobe", strobe_o, 1'b0);
        chk("R1", "reset enable", en_n_o, 1'b1);
        chk("R1", "reset busy", busy_o, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;

        // Table of transfers: R2, R4, R5, R6, R7, R9, R10
        for (int i = 0; i < NVEC; i++)
            xfer(VEC[i][38], VEC[i][37:32], VEC[i][31:0], 0);

        // R8: start while busy is ignored (strobe target, then enable target)
        xfer(1'b0, 6'd8, 32'h0000_00C3, 3);
        xfer(1'b1, 6'd6, 32'h0000_0029, 5);

        // R3: pins launch on the falling edge
        @(posedge clk); #1;
        start_i = 1'b1; sel_i = 1'b0; nbits_i = 6'd4; word_i = 32'h0000_0005;
        @(posedge clk); #1;
        start_i = 1'b0;
        chk("R3", "data unchanged after accepting edge", data_o, 1'b0);
        chk("R8", "busy after accepting edge", busy_o, 1'b1);
        sample();
        chk("R3", "first bit after falling edge", data_o, 1'b0);
        @(posedge clk); #1;
        chk("R3", "bit held past rising edge", data_o, 1'b0);
        sample();
        chk("R3", "second bit after falling edge", data_o, 1'b1);

        // R1: reset in the middle of a frame returns pins to idle
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        sample();
        chk("R1", "mid-frame reset data", data_o, 1'b0);
        chk("R1", "mid-frame reset busy", busy_o, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;
        xfer(1'b1, 6'd3, 32'h0000_0006, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule